// File: doc/BRIEF.md
# Pipelined 8-bit Execute Stage

This block is the execute stage of a small RISC pipeline with an 8-bit data path. Every clock it takes a 5-bit opcode, two operands `A` and `B`, and the value on an external input port. For immediate-form instructions the decoder upstream places the immediate on `B`. The stage registers an 8-bit result, an 8-bit output-port value and four status flags: parity, overflow, zero and carry. Fetch, decode, the register file, data memory, hazard handling and branch evaluation live elsewhere in the pipeline.

Internally the opcode is decoded into two things. The first is an operation class: arithmetic, logic, memory pass-through, output, or hold. The second is an ALU function. The class alone decides which flags are updated and which are forced to zero. It also decides whether the result register takes the new ALU value or keeps its old one. Control opcodes (return, halt, jumps) and unused codes hold the result. This lets the downstream stages see a stable value while the front end redirects. The stage accepts one instruction per cycle.

Top module: `exe_stage`

## Requirements
- R1: A synchronous active-high reset clears the result, the output-port register and all four flags at the next rising edge.
- R2: Add (register 00000, immediate 01000) gives result = A + B modulo 256. Carry is the unsigned carry out. Overflow is set when both operands have the same sign and the result's sign differs.
- R3: Subtract (register 00001, immediate 01001) gives result = A − B modulo 256. Carry is the borrow, set when A < B unsigned. Overflow is set when the operand signs differ and the result's sign differs from A.
- R4: Move (00010/01010) yields B. AND (00100/01100), OR (00101/01101) and XOR (00110/01110) combine A and B. NOT (00111/01111) yields ~B. Each of these forces carry and overflow to 0.
- R5: 11001 shifts A left, 11010 shifts A right logically and 11011 shifts A right arithmetically (sign fill). The shift amount is the full 8-bit value of B, so amounts of 8 or more give 0, or all sign bits for the arithmetic shift. Carry and overflow are forced to 0.
- R6: IN (10110) loads the result from the data input port. Carry and overflow are forced to 0.
- R7: LD (10100) and ST (10101) pass A through as the result and clear all four flags.
- R8: RET 10000, HLT 10001, JMP 11000, JC 11100, JNC 11101, JZ 11110, JNZ 11111 and the unused codes 00011, 01011, 10010 and 10011 keep the previous result and clear all four flags.
- R9: OUT (10111) loads A into the output-port register, keeps the previous result and clears all flags. No other opcode changes the output-port register.
- R10: For the classes that update them (R2–R6), parity is 1 when the new result has an even number of 1 bits, and zero is 1 when the new result equals 0.
- R11: Result, flags and output port are registered. Values presented before a rising edge appear after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Opcode |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B or immediate |
| din_i | input | 8 | External input port value |
| res_o | output | 8 | Registered result |
| dout_o | output | 8 | Registered output-port value |
| par_o | output | 1 | Parity flag (even parity) |
| ovf_o | output | 1 | Signed overflow flag |
| zero_o | output | 1 | Zero flag |
| cry_o | output | 1 | Carry / borrow flag |

## Verification
The bench builds the stage with its default width, `DATA_W = 8`. At that width the signed boundaries 0x7F/0x80 and the carry and borrow boundaries at 0x00/0xFF can be reached with ordinary operands. So can a shift amount that exceeds the word width. A sequence of hold-class opcodes after a flag-setting add shows both behaviours: the result is retained and the flags are cleared. The bench also checks that the output port is loaded only by OUT, that a reset applied mid-run clears everything, and that the outputs do not move before the clock edge.

// File: rtl/exe_pkg.sv
package exe_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'b00000,
        OP_SUB  = 5'b00001,
        OP_MOV  = 5'b00010,
        OP_AND  = 5'b00100,
        OP_OR   = 5'b00101,
        OP_XOR  = 5'b00110,
        OP_NOT  = 5'b00111,
        OP_ADI  = 5'b01000,
        OP_SBI  = 5'b01001,
        OP_MVI  = 5'b01010,
        OP_ANI  = 5'b01100,
        OP_ORI  = 5'b01101,
        OP_XRI  = 5'b01110,
        OP_NTI  = 5'b01111,
        OP_RET  = 5'b10000,
        OP_HLT  = 5'b10001,
        OP_LD   = 5'b10100,
        OP_ST   = 5'b10101,
        OP_IN   = 5'b10110,
        OP_OUT  = 5'b10111,
        OP_JMP  = 5'b11000,
        OP_SHL  = 5'b11001,
        OP_SHR  = 5'b11010,
        OP_SAR  = 5'b11011,
        OP_JC   = 5'b11100,
        OP_JNC  = 5'b11101,
        OP_JZ   = 5'b11110,
        OP_JNZ  = 5'b11111
    } op_e;

    // Operation class: selects the flag policy and result source
    typedef enum logic [2:0] {
        CLS_ARITH,   // all four flags from the new result
        CLS_LOGIC,   // parity/zero from the new result, carry/overflow cleared
        CLS_PASS,    // new result taken, all flags cleared
        CLS_OUT,     // output port loaded, result held, flags cleared
        CLS_HOLD     // result held, flags cleared
    } cls_e;

    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_B, FN_AND, FN_OR, FN_XOR, FN_NOTB,
        FN_SHL, FN_SHR, FN_SAR, FN_DIN, FN_A
    } fn_e;

    typedef struct packed {
        logic p;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/exe_decode.sv
module exe_decode
    import exe_pkg::*;
(
    input  logic [4:0] op_i,
    output cls_e       cls_o,
    output fn_e        fn_o
);

    always_comb begin
        cls_o = CLS_HOLD;
        fn_o  = FN_A;
        unique case (op_i)
            OP_ADD, OP_ADI: begin cls_o = CLS_ARITH; fn_o = FN_ADD;  end
            OP_SUB, OP_SBI: begin cls_o = CLS_ARITH; fn_o = FN_SUB;  end
            OP_MOV, OP_MVI: begin cls_o = CLS_LOGIC; fn_o = FN_B;    end
            OP_AND, OP_ANI: begin cls_o = CLS_LOGIC; fn_o = FN_AND;  end
            OP_OR,  OP_ORI: begin cls_o = CLS_LOGIC; fn_o = FN_OR;   end
            OP_XOR, OP_XRI: begin cls_o = CLS_LOGIC; fn_o = FN_XOR;  end
            OP_NOT, OP_NTI: begin cls_o = CLS_LOGIC; fn_o = FN_NOTB; end
            OP_SHL:         begin cls_o = CLS_LOGIC; fn_o = FN_SHL;  end
            OP_SHR:         begin cls_o = CLS_LOGIC; fn_o = FN_SHR;  end
            OP_SAR:         begin cls_o = CLS_LOGIC; fn_o = FN_SAR;  end
            OP_IN:          begin cls_o = CLS_LOGIC; fn_o = FN_DIN;  end
            OP_LD,  OP_ST:  begin cls_o = CLS_PASS;  fn_o = FN_A;    end
            OP_OUT:         begin cls_o = CLS_OUT;   fn_o = FN_A;    end
            default:        begin cls_o = CLS_HOLD;  fn_o = FN_A;    end
        endcase
    end

endmodule

// File: rtl/exe_alu.sv
module exe_alu
    import exe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  fn_e               fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cry_o,
    output logic              ovf_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] dif_w;

    assign sum_w = {1'b0, a_i} + {1'b0, b_i};
    assign dif_w = {1'b0, a_i} - {1'b0, b_i};

    always_comb begin
        res_o = a_i;
        cry_o = 1'b0;
        ovf_o = 1'b0;
        unique case (fn_i)
            FN_ADD: begin
                res_o = sum_w[MSB:0];
                cry_o = sum_w[DATA_W];
                ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
            end
            FN_SUB: begin
                res_o = dif_w[MSB:0];
                cry_o = dif_w[DATA_W];
                ovf_o = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);
            end
            FN_B:    res_o = b_i;
            FN_AND:  res_o = a_i & b_i;
            FN_OR:   res_o = a_i | b_i;
            FN_XOR:  res_o = a_i ^ b_i;
            FN_NOTB: res_o = ~b_i;
            FN_SHL:  res_o = a_i << b_i;
            FN_SHR:  res_o = a_i >> b_i;
            FN_SAR:  res_o = $unsigned($signed(a_i) >>> b_i);
            FN_DIN:  res_o = din_i;
            FN_A:    res_o = a_i;
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/exe_flags.sv
module exe_flags
    import exe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  cls_e              cls_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              cry_i,
    input  logic              ovf_i,
    output flags_t            flags_o
);

    logic par_w;
    logic zro_w;

    assign par_w = ~(^res_i);
    assign zro_w = (res_i == '0);

    always_comb begin
        flags_o = '0;
        unique case (cls_i)
            CLS_ARITH: flags_o = '{p: par_w, v: ovf_i, z: zro_w, c: cry_i};
            CLS_LOGIC: flags_o = '{p: par_w, v: 1'b0,  z: zro_w, c: 1'b0};
            CLS_PASS, CLS_OUT, CLS_HOLD: flags_o = '0;
            default:   flags_o = '0;
        endcase
    end

endmodule

// File: rtl/exe_stage.sv
module exe_stage
    import exe_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] dout_o,
    output logic              par_o,
    output logic              ovf_o,
    output logic              zero_o,
    output logic              cry_o
);

    cls_e              cls_w;
    fn_e               fn_w;
    logic [DATA_W-1:0] alu_res_w;
    logic              alu_cry_w;
    logic              alu_ovf_w;
    flags_t            flags_nxt_w;

    logic [DATA_W-1:0] res_q, res_d;
    logic [DATA_W-1:0] dout_q, dout_d;
    flags_t            flags_q;

    exe_decode u_dec (
        .op_i  (op_i),
        .cls_o (cls_w),
        .fn_o  (fn_w)
    );

    exe_alu #(.DATA_W(DATA_W)) u_alu (
        .fn_i  (fn_w),
        .a_i   (a_i),
        .b_i   (b_i),
        .din_i (din_i),
        .res_o (alu_res_w),
        .cry_o (alu_cry_w),
        .ovf_o (alu_ovf_w)
    );

    exe_flags #(.DATA_W(DATA_W)) u_flg (
        .cls_i   (cls_w),
        .res_i   (alu_res_w),
        .cry_i   (alu_cry_w),
        .ovf_i   (alu_ovf_w),
        .flags_o (flags_nxt_w)
    );

    // Next-value selection per class
    always_comb begin
        res_d  = res_q;
        dout_d = dout_q;
        unique case (cls_w)
            CLS_ARITH, CLS_LOGIC, CLS_PASS: res_d = alu_res_w;
            CLS_OUT:  dout_d = a_i;
            CLS_HOLD: res_d = res_q;
            default:  res_d = res_q;
        endcase
    end

    // State registers
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            dout_q  <= '0;
            flags_q <= '0;
        end else begin
            res_q   <= res_d;
            dout_q  <= dout_d;
            flags_q <= flags_nxt_w;
        end
    end

    assign res_o  = res_q;
    assign dout_o = dout_q;
    assign par_o  = flags_q.p;
    assign ovf_o  = flags_q.v;
    assign zero_o = flags_q.z;
    assign cry_o  = flags_q.c;

    // Assertions
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (res_o == '0 && dout_o == '0 && !par_o && !ovf_o && !zero_o && !cry_o));

    p_no_cv_logic_r4: assert property (@(posedge clk) disable iff (rst)
        (cls_w == CLS_LOGIC) |=> (!cry_o && !ovf_o));

    p_pass_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (cls_w == CLS_PASS) |=> (res_o == $past(a_i) && !par_o && !ovf_o && !zero_o && !cry_o));

    p_hold_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (cls_w == CLS_HOLD || cls_w == CLS_OUT) |=> ($stable(res_o) && !par_o && !ovf_o && !zero_o && !cry_o));

    p_out_load_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_OUT) |=> (dout_o == $past(a_i)));

    p_out_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (op_i != OP_OUT) |=> $stable(dout_o));

    p_zero_match_r10: assert property (@(posedge clk) disable iff (rst)
        zero_o |-> (res_o == '0));

    p_parity_match_r10: assert property (@(posedge clk) disable iff (rst)
        par_o |-> ($countones(res_o) % 2 == 0));

endmodule

// File: tb/tb_exe_stage.sv
module tb_exe_stage;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op  = 5'b10001;
    logic [7:0] a   = '0;
    logic [7:0] b   = '0;
    logic [7:0] din = '0;
    logic [7:0] res, dout;
    logic       par, ovf, zro, cry;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    exe_stage dut (
        .clk(clk), .rst(rst), .op_i(op), .a_i(a), .b_i(b), .din_i(din),
        .res_o(res), .dout_o(dout), .par_o(par), .ovf_o(ovf), .zero_o(zro), .cry_o(cry)
    );

    // {op, a, b, din, expected result, expected flags {P,V,Z,C}}
    localparam int NV = 40;
    localparam logic [40:0] VEC [0:NV-1] = '{
        {5'b00000, 8'h05, 8'h03, 8'h00, 8'h08, 4'b0000},
        {5'b00000, 8'h7F, 8'h01, 8'h00, 8'h80, 4'b0100},
        {5'b00000, 8'hFF, 8'h01, 8'h00, 8'h00, 4'b1011},
        {5'b01000, 8'h80, 8'h80, 8'h00, 8'h00, 4'b1111},
        {5'b00001, 8'h05, 8'h03, 8'h00, 8'h02, 4'b0000},
        {5'b00001, 8'h03, 8'h05, 8'h00, 8'hFE, 4'b0001},
        {5'b01001, 8'h80, 8'h01, 8'h00, 8'h7F, 4'b0100},
        {5'b00001, 8'h44, 8'h44, 8'h00, 8'h00, 4'b1010},
        {5'b00010, 8'h12, 8'h3C, 8'h00, 8'h3C, 4'b1000},
        {5'b01010, 8'h12, 8'h00, 8'h00, 8'h00, 4'b1010},
        {5'b00100, 8'hF0, 8'h3C, 8'h00, 8'h30, 4'b1000},
        {5'b01100, 8'h0F, 8'hF0, 8'h00, 8'h00, 4'b1010},
        {5'b00101, 8'h01, 8'h02, 8'h00, 8'h03, 4'b1000},
        {5'b01101, 8'h80, 8'h00, 8'h00, 8'h80, 4'b0000},
        {5'b00110, 8'hFF, 8'h0F, 8'h00, 8'hF0, 4'b1000},
        {5'b01110, 8'hAA, 8'h01, 8'h00, 8'hAB, 4'b0000},
        {5'b00111, 8'h55, 8'h0F, 8'h00, 8'hF0, 4'b1000},
        {5'b01111, 8'h55, 8'hFF, 8'h00, 8'h00, 4'b1010},
        {5'b11001, 8'h81, 8'h01, 8'h00, 8'h02, 4'b0000},
        {5'b11001, 8'h01, 8'h08, 8'h00, 8'h00, 4'b1010},
        {5'b11010, 8'h80, 8'h03, 8'h00, 8'h10, 4'b0000},
        {5'b11011, 8'h80, 8'h03, 8'h00, 8'hF0, 4'b1000},
        {5'b11011, 8'h80, 8'h09, 8'h00, 8'hFF, 4'b1000},
        {5'b11011, 8'h40, 8'h02, 8'h00, 8'h10, 4'b0000},
        {5'b10110, 8'h00, 8'h00, 8'h5A, 8'h5A, 4'b1000},
        {5'b10110, 8'h77, 8'h77, 8'h00, 8'h00, 4'b1010},
        {5'b00000, 8'hFF, 8'hFF, 8'h00, 8'hFE, 4'b0001},
        {5'b10000, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b10001, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b11000, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b11100, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b11101, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b11110, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b11111, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b00011, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b10010, 8'h11, 8'h22, 8'h33, 8'hFE, 4'b0000},
        {5'b10100, 8'h33, 8'h00, 8'h00, 8'h33, 4'b0000},
        {5'b00000, 8'h80, 8'h80, 8'h00, 8'h00, 4'b1111},
        {5'b10101, 8'hC5, 8'h00, 8'h00, 8'hC5, 4'b0000},
        {5'b10111, 8'h99, 8'h00, 8'h00, 8'hC5, 4'b0000}
    };

    function automatic string req_of(input logic [4:0] o);
        case (o)
            5'b00000, 5'b01000: return "R2/R10";
            5'b00001, 5'b01001: return "R3/R10";
            5'b11001, 5'b11010, 5'b11011: return "R5/R10";
            5'b10110: return "R6/R10";
            5'b10100, 5'b10101: return "R7";
            5'b10111: return "R9";
            5'b00010, 5'b01010, 5'b00100, 5'b01100, 5'b00101, 5'b01101,
            5'b00110, 5'b01110, 5'b00111, 5'b01111: return "R4/R10";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] ar, input logic [7:0] er,
                         input logic [7:0] ad, input logic [7:0] ed,
                         input logic [3:0] af, input logic [3:0] ef);
        checks++;
        if (ar !== er || ad !== ed || af !== ef) begin
            fails++;
            $display("FAIL %s: res=%h dout=%h flags=%b, expected res=%h dout=%h flags=%b",
                     req, ar, ad, af, er, ed, ef);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] exp_dout;
        exp_dout = 8'h00;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", res, 8'h00, dout, 8'h00, {par, ovf, zro, cry}, 4'b0000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            v   = VEC[i];
            op  = v[40:36];
            a   = v[35:28];
            b   = v[27:20];
            din = v[19:12];
            if (v[40:36] == 5'b10111) exp_dout = v[35:28];
            @(negedge clk);
            check(req_of(v[40:36]), res, v[11:4], dout, exp_dout, {par, ovf, zro, cry}, v[3:0]);
        end

        // R9: output port untouched by non-OUT opcodes
        op = 5'b00000; a = 8'h01; b = 8'h01;
        @(negedge clk);
        check("R9", res, 8'h02, dout, 8'h99, {par, ovf, zro, cry}, 4'b0000);
        op = 5'b10110; din = 8'h3C;
        @(negedge clk);
        check("R9", res, 8'h3C, dout, 8'h99, {par, ovf, zro, cry}, 4'b1000);

        // R11: registered outputs do not move before the edge
        op = 5'b00001; a = 8'h00; b = 8'h01;
        @(posedge clk);
        #1;
        op = 5'b10001;
        @(negedge clk);
        check("R11", res, 8'hFF, dout, 8'h99, {par, ovf, zro, cry}, 4'b1001);
        op = 5'b00000; a = 8'h10; b = 8'h20;
        #2;
        check("R11", res, 8'hFF, dout, 8'h99, {par, ovf, zro, cry}, 4'b1001);
        @(negedge clk);
        check("R11", res, 8'h30, dout, 8'h99, {par, ovf, zro, cry}, 4'b1000);

        // R1: reset applied mid-run
        op = 5'b00000; a = 8'hFF; b = 8'hFF;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", res, 8'h00, dout, 8'h00, {par, ovf, zro, cry}, 4'b0000);
        rst = 1'b0;
        op  = 5'b10001;
        @(negedge clk);
        check("R8", res, 8'h00, dout, 8'h00, {par, ovf, zro, cry}, 4'b0000);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule